// File: doc/BRIEF.md
# Two-Operand ALU with Condition Flags

This block performs the logic and arithmetic work of a small 32-bit processor. A caller presents an opcode, a first operand, a register value and a 12-bit immediate. The opcode decides whether the second operand is the register value or the sign-extended immediate. The block returns the result combinationally.

The block holds a 4-bit flags register with four flags: carry/overflow, negative, zero and positive. Each instruction carries a 4-bit condition mask. The block compares that mask with the stored flags and raises a pass signal when every selected flag is set. Only an issued ALU instruction whose condition passes writes the flags, and that write happens on the clock edge. Any flag the operation does not produce is written as zero. Decode, register file access and memory operations are the caller's job.

Top module: `alu_flags`

## Requirements
- R1: The immediate opcodes 1, 3, 5, 7, 9, 12, 14 and 16 use `rhs_imm` sign-extended from bit 11 as the second operand. Every other opcode uses `rhs_reg`.
- R2: Opcodes 0/1 shift `opa` left and opcodes 2/3 shift it right, logically. The shift count is the low 5 bits of the second operand.
- R3: Opcodes 4/5 give AND, 6/7 give OR and 8/9 give XOR. Opcode 10 gives the bitwise inverse of `opa`, and the second operand has no effect on it.
- R4: Opcodes 11/12 give `opa` plus the second operand, and C is the carry out of bit 31. Opcodes 13/14 give `opa` minus the second operand, and C is set when an unsigned borrow occurs.
- R5: Opcodes 15/16 give the low 32 bits of the unsigned product. C is set when the upper 32 bits of the product are nonzero.
- R6: The flags word is {C, N, Z, P}, with C at bit 3 and P at bit 0. N is set when result bit 31 is 1. Z is set when the result is zero. P is set when the result is nonzero and bit 31 is 0. C is cleared for shifts and logic operations.
- R7: `cond_pass` is 1 exactly when every flag selected by a 1 in `cond` (same bit positions as the flags word) is set in the stored flags. A mask of 0 always passes.
- R8: The flags load on a rising clock edge only when `issue` is 1, `cond_pass` is 1 and the opcode is 16 or below. Otherwise the flags keep their value.
- R9: While `rst_n` is low, the flags are 0.
- R10: Opcodes above 16 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Operation code |
| cond | input | 4 | Condition mask, bit 3 C, bit 2 N, bit 1 Z, bit 0 P |
| opa | input | 32 | First operand |
| rhs_reg | input | 32 | Register second operand |
| rhs_imm | input | 12 | Signed immediate second operand |
| result | output | 32 | Operation result |
| cond_pass | output | 1 | Condition mask satisfied by stored flags |
| flags | output | 4 | Stored flags {C, N, Z, P} |

## Verification
The bench uses the default parameters: a 32-bit datapath, a 12-bit immediate and a 6-bit opcode. With these values the carry out of bit 31 and the sign bit of the immediate at bit 11 are easy to reach with directed operands. The same holds for shift counts above 31, which must wrap to their low 5 bits, and for products that spill past 32 bits. Random operands, opcodes and masks also produce skipped instructions and out-of-range opcodes, so the rule that the flags hold in those cases is exercised alongside the updates.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 12,
  parameter int OP_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [OP_W-1:0]  opcode,
  input  logic [3:0]       cond,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] rhs_reg,
  input  logic [IMM_W-1:0] rhs_imm,
  output logic [WIDTH-1:0] result,
  output logic             cond_pass,
  output logic [3:0]       flags
);
  localparam int SH_W = $clog2(WIDTH);
  localparam logic [OP_W-1:0] LAST_ALU = OP_W'(16);

  logic             use_imm;
  logic [WIDTH-1:0] opb;
  logic [WIDTH:0]   sum, diff;
  logic [2*WIDTH-1:0] prod;
  logic             carry;
  logic             is_alu;
  logic             load;
  logic [3:0]       next_flags;

  always_comb begin
    case (opcode)
      OP_W'(1), OP_W'(3), OP_W'(5), OP_W'(7),
      OP_W'(9), OP_W'(12), OP_W'(14), OP_W'(16): use_imm = 1'b1;
      default: use_imm = 1'b0;
    endcase
  end

  assign opb  = use_imm ? {{(WIDTH-IMM_W){rhs_imm[IMM_W-1]}}, rhs_imm} : rhs_reg;
  assign sum  = {1'b0, opa} + {1'b0, opb};
  assign diff = {1'b0, opa} - {1'b0, opb};
  assign prod = {{WIDTH{1'b0}}, opa} * {{WIDTH{1'b0}}, opb};

  always_comb begin
    result = '0;
    carry  = 1'b0;
    case (opcode)
      OP_W'(0), OP_W'(1):   result = opa << opb[SH_W-1:0];
      OP_W'(2), OP_W'(3):   result = opa >> opb[SH_W-1:0];
      OP_W'(4), OP_W'(5):   result = opa & opb;
      OP_W'(6), OP_W'(7):   result = opa | opb;
      OP_W'(8), OP_W'(9):   result = opa ^ opb;
      OP_W'(10):            result = ~opa;
      OP_W'(11), OP_W'(12): begin result = sum[WIDTH-1:0];  carry = sum[WIDTH];  end
      OP_W'(13), OP_W'(14): begin result = diff[WIDTH-1:0]; carry = diff[WIDTH]; end
      OP_W'(15), OP_W'(16): begin
        result = prod[WIDTH-1:0];
        carry  = |prod[2*WIDTH-1:WIDTH];
      end
      default: ;
    endcase
  end

  assign cond_pass  = (flags & cond) == cond;
  assign is_alu     = opcode <= LAST_ALU;
  assign load       = issue && cond_pass && is_alu;
  assign next_flags = {carry, result[WIDTH-1], result == '0,
                       !result[WIDTH-1] && (result != '0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags <= 4'b0000;
    else if (load) flags <= next_flags;
  end
endmodule

module alu_flags_chk #(
  parameter int WIDTH = 32,
  parameter int OP_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [OP_W-1:0]  opcode,
  input logic [3:0]       cond,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] result,
  input logic             cond_pass,
  input logic [3:0]       flags
);
  logic upd;
  assign upd = issue && cond_pass && (opcode <= OP_W'(16));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags));
  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'b0000) |-> cond_pass);
  p_sign_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags[2:0]));
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags[1] == ($past(result) == '0));
  p_neg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags[2] == $past(result[WIDTH-1]));
  p_not_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_W'(10)) |-> result == ~opa);
  p_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode > OP_W'(16)) |-> result == '0);
endmodule

bind alu_flags alu_flags_chk #(.WIDTH(WIDTH), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .cond(cond),
  .opa(opa), .result(result), .cond_pass(cond_pass), .flags(flags)
);

// File: tb/sim_alu_flags.sv
module sim_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [5:0]  opcode = '0;
  logic [3:0]  cond = '0;
  logic [31:0] opa = '0, rhs_reg = '0;
  logic [11:0] rhs_imm = '0;
  logic [31:0] result;
  logic        cond_pass;
  logic [3:0]  flags;

  int checks = 0, fails = 0;
  logic [3:0] mflags = 4'b0000;
  bit done = 0;

  always #10 clk = ~clk;

  alu_flags u0 (.clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .cond(cond), .opa(opa), .rhs_reg(rhs_reg), .rhs_imm(rhs_imm),
    .result(result), .cond_pass(cond_pass), .flags(flags));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit imm_form(logic [5:0] op);
    return op inside {1, 3, 5, 7, 9, 12, 14, 16};
  endfunction

  function automatic logic [32:0] model(logic [5:0] op, logic [31:0] a, logic [31:0] b);
    longint unsigned p;
    logic [32:0] w;
    case (op)
      0, 1:   return {1'b0, a << b[4:0]};
      2, 3:   return {1'b0, a >> b[4:0]};
      4, 5:   return {1'b0, a & b};
      6, 7:   return {1'b0, a | b};
      8, 9:   return {1'b0, a ^ b};
      10:     return {1'b0, ~a};
      11, 12: begin w = {1'b0, a} + {1'b0, b}; return w; end
      13, 14: return {(a < b), a - b};
      15, 16: begin
        p = longint'(a) * longint'(b);
        return {(p[63:32] != 0), p[31:0]};
      end
      default: return 33'd0;
    endcase
  endfunction

  task automatic step(string req, bit iss, logic [5:0] op, logic [3:0] cm,
                      logic [31:0] a, logic [31:0] r, logic [11:0] im);
    logic [31:0] b;
    logic [32:0] m;
    bit pass;
    @(negedge clk);
    issue = iss; opcode = op; cond = cm; opa = a; rhs_reg = r; rhs_imm = im;
    #1;
    b = imm_form(op) ? {{20{im[11]}}, im} : r;
    m = model(op, a, b);
    pass = (mflags & cm) == cm;
    check({req, " result"}, result, m[31:0]);
    check("R7 cond_pass", {31'd0, cond_pass}, {31'd0, pass});
    if (iss && pass && op <= 16)
      mflags = {m[32], m[31], m[31:0] == 0, !m[31] && m[31:0] != 0};
    @(posedge clk); #1;
    check({req, " R6 R8 flags"}, {28'd0, flags}, {28'd0, mflags});
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #25;
    check("R9 reset flags", {28'd0, flags}, 32'd0);
    rst_n = 1'b1;
    // R4 add carry to zero
    step("R4", 1, 11, 0, 32'hFFFF_FFFF, 32'd1, 0);
    check("R4 C and Z", {28'd0, flags}, 32'hA);
    // R7 mask C|Z passes now, mask N fails and flags hold (R8)
    step("R7", 1, 4, 4'b1010, 32'hF0, 32'h3C, 0);
    step("R8 skip", 1, 13, 4'b0100, 32'd1, 32'd9, 0);
    check("R8 skipped keeps flags", {28'd0, flags}, 32'h1);
    // R4 subtract borrow
    step("R4 sub", 1, 13, 0, 32'd5, 32'd7, 0);
    check("R4 borrow C N", {28'd0, flags}, 32'hC);
    // R1 immediate sign extension: 1 + (-1)
    step("R1", 1, 12, 0, 32'd1, 32'h1234, 12'hFFF);
    check("R1 imm -1 gives zero", result, 32'd0);
    // R2 shift count uses low 5 bits
    step("R2", 1, 0, 0, 32'd3, 32'd33, 0);
    check("R2 shift by 33 as 1", result, 32'd6);
    step("R2 right", 1, 3, 0, 32'h8000_0000, 0, 12'd31);
    // R3 NOT ignores second operand
    step("R3 not", 1, 10, 0, 32'h0F0F_0000, 32'hDEAD_BEEF, 12'h5A5);
    // R5 multiply overflow
    step("R5", 1, 15, 0, 32'h0001_0000, 32'h0001_0000, 0);
    check("R5 C on overflow", {28'd0, flags}, 32'hA);
    // R10 out-of-range opcode, flags kept (R8)
    step("R10", 1, 29, 0, 32'hFFFF, 32'hFFFF, 0);
    step("R8 not issued", 0, 11, 0, 32'd7, 32'd7, 0);
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op = 6'($urandom % 22);
      logic [3:0] cm = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0000;
      step("R1 R3 R4 R5 random", 1'($urandom % 8 != 0), op, cm,
           (i % 5 == 0) ? 32'hFFFF_FFFF : $urandom, $urandom, 12'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial void'($urandom(32'd12345));
endmodule